// File: doc/BRIEF.md
# Protected System-Control Register Unit

This block is a small set of control registers reached over a plain synchronous register bus: an address, write data, a write strobe and combinational read data. A protect register holds an enable bit. While that bit is set, software may change two processor-mode registers. One of them carries a software-reset command. The other carries a wait-state select and three lock bits. A lock bit can be raised by a write but never lowered by one.

Once raised, the lock bits pin down part of the chip's clock configuration. The clock lock keeps the bus clock running through wait instructions. It also vetoes writes to four bits of a small clock-control register. The watchdog lock moves the watchdog count source to the ring oscillator, keeps the watchdog counting in wait and hold states, and vetoes stop-mode entry. The third lock bit gives a shared pin its NMI function.

A software reset is a registered single-cycle pulse. On the edge that follows it, the pulse returns every register to its reset value. A sticky flag records that a software reset took place, so that memory contents can be kept. The bus has no stream traffic, so there is no valid/ready handshake: each write completes in the cycle its strobe is high, and reads are combinational.

Top module: `sysctl_regs`

## Requirements
- R1: After a hardware reset, reads of addresses 0x04, 0x06, 0x0A and 0x1E return 0, and every output is 0.
- R2: Bit 1 of the protect register at 0x0A is freely readable and writable. Its other bits always read 0.
- R3: While protect bit 1 is 0, writes to 0x04 and 0x1E are ignored: the read value of 0x1E, the outputs and the reset pulse are unchanged.
- R4: Bit 0 of 0x1E can be written either way while unlocked. Output `sfr_one_wait` follows it (1 = one wait, 0 = two waits).
- R5: Bits 1, 2 and 4 of 0x1E are set by writing 1. Writing 0 leaves them set.
- R6: Bits 3 and 7:5 of 0x1E read 0 whatever is written. Address 0x04 always reads 0.
- R7: Clock-control register at 0x06: bit 0 stops the main clock, bit 1 selects the CPU clock source, bit 2 requests stop mode, bit 3 enables oscillation-stop detection, and bit 4 is a general bit. Bits 7:5 read 0. Each bit drives its output and reads back as written unless a lock vetoes it.
- R8: While 0x1E bit 1 (clock lock) is 1, writes leave 0x06 bits 3:0 unchanged, and `bclk_keep` is 1.
- R9: While 0x1E bit 2 (watchdog lock) is 1, `wdt_src_ring` and `wdt_run_in_wait` are 1, and writes leave 0x06 bit 2 unchanged.
- R10: `nmi_pin_en` equals 0x1E bit 4.
- R11: Writing a value with bit 3 set to 0x04 while protect bit 1 is 1 makes `swrst_pulse` high for exactly the one cycle after the write edge.
- R12: On the edge where `swrst_pulse` is high, all registers return to their reset values, and `swrst_seen` becomes 1. `swrst_seen` stays 1 until a hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Combinational read data |
| sfr_one_wait | output | 1 | 1 = one wait state, 0 = two |
| wdt_src_ring | output | 1 | Watchdog counts the ring oscillator |
| wdt_run_in_wait | output | 1 | Watchdog keeps counting in wait/hold |
| nmi_pin_en | output | 1 | Shared pin acts as NMI |
| bclk_keep | output | 1 | Bus clock not halted by wait |
| main_clk_stop | output | 1 | Main clock stop request |
| cpu_clk_sel | output | 1 | CPU clock source select |
| stop_mode_req | output | 1 | Stop-mode entry request |
| osc_det_en | output | 1 | Oscillation-stop detection enable |
| swrst_pulse | output | 1 | One-cycle software-reset pulse |
| swrst_seen | output | 1 | Sticky: a software reset occurred |

## Verification
Every one of the 256 values is written to 0x1E from a fresh reset, and then a write of 0 follows. This separates the freely writable bit from the set-only bits, and both of those from the bits that always read 0.

All 256 write values are then applied in sequence to the clock-control register under each of the four lock combinations. Each combination starts with all clock bits set, so a vetoed bit that is wrongly cleared shows up.

Writes made while the protect bit is clear, and reset commands with bit 3 clear, show that the protect gate and the command decode work apart from each other. A full software-reset sequence checks the pulse width, the clearing of all registers, and how long the sticky flag lasts.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam logic [7:0] A_PM0  = 8'h04;
  localparam logic [7:0] A_CKC  = 8'h06;
  localparam logic [7:0] A_PROT = 8'h0A;
  localparam logic [7:0] A_PM2  = 8'h1E;

  localparam int PROT_PMEN = 1;
  localparam int PM0_SWRST = 3;

  localparam int PM2_WAIT  = 0;
  localparam int PM2_CLKLK = 1;
  localparam int PM2_WDTLK = 2;
  localparam int PM2_NMI   = 4;

  localparam int CK_MSTOP = 0;
  localparam int CK_CSEL  = 1;
  localparam int CK_STOP  = 2;
  localparam int CK_OSCD  = 3;
  localparam int CK_GP    = 4;
  localparam int CK_BITS  = 5;
endpackage

// File: rtl/sysctl_prot.sv
module sysctl_prot
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_prot,
  input  logic              wr_pm0,
  input  logic [DATA_W-1:0] wdata,
  output logic              pm_en,
  output logic              swrst_pulse,
  output logic              swrst_seen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_en       <= 1'b0;
      swrst_pulse <= 1'b0;
      swrst_seen  <= 1'b0;
    end else if (swrst_pulse) begin
      pm_en       <= 1'b0;
      swrst_pulse <= 1'b0;
      swrst_seen  <= 1'b1;
    end else begin
      if (wr_prot) pm_en <= wdata[PROT_PMEN];
      swrst_pulse <= wr_pm0 && pm_en && wdata[PM0_SWRST];
    end
  end

  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_pulse |=> !swrst_pulse);
  p_pulse_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swrst_pulse) |-> $past(wr_pm0 && pm_en));
  p_seen_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(swrst_seen));
endmodule

// File: rtl/sysctl_pmode2.sv
module sysctl_pmode2
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wr_pm2,
  input  logic              pm_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              wait_one,
  output logic              clk_lock,
  output logic              wdt_lock,
  output logic              nmi_en,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_one <= 1'b0;
      clk_lock <= 1'b0;
      wdt_lock <= 1'b0;
      nmi_en   <= 1'b0;
    end else if (soft_clr) begin
      wait_one <= 1'b0;
      clk_lock <= 1'b0;
      wdt_lock <= 1'b0;
      nmi_en   <= 1'b0;
    end else if (wr_pm2 && pm_en) begin
      wait_one <= wdata[PM2_WAIT];
      clk_lock <= clk_lock | wdata[PM2_CLKLK];
      wdt_lock <= wdt_lock | wdata[PM2_WDTLK];
      nmi_en   <= nmi_en   | wdata[PM2_NMI];
    end
  end

  always_comb begin
    rdata            = '0;
    rdata[PM2_WAIT]  = wait_one;
    rdata[PM2_CLKLK] = clk_lock;
    rdata[PM2_WDTLK] = wdt_lock;
    rdata[PM2_NMI]   = nmi_en;
  end

  p_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pm_en && !soft_clr) |=> $stable(rdata));
  p_clklock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_lock) |-> $past(soft_clr));
  p_wdtlock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_lock) |-> $past(soft_clr));
  p_nmi_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_en) |-> $past(soft_clr));
endmodule

// File: rtl/sysctl_clkctl.sv
module sysctl_clkctl
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic               wr_ckc,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               clk_lock,
  input  logic               wdt_lock,
  output logic [CK_BITS-1:0] ckc,
  output logic [DATA_W-1:0]  rdata
);
  logic [CK_BITS-1:0] veto;

  always_comb begin
    veto           = '0;
    veto[CK_MSTOP] = clk_lock;
    veto[CK_CSEL]  = clk_lock;
    veto[CK_STOP]  = clk_lock | wdt_lock;
    veto[CK_OSCD]  = clk_lock;
  end

  for (genvar i = 0; i < CK_BITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ckc[i] <= 1'b0;
      else if (soft_clr)            ckc[i] <= 1'b0;
      else if (wr_ckc && !veto[i])  ckc[i] <= wdata[i];
    end
  end

  always_comb begin
    rdata              = '0;
    rdata[CK_BITS-1:0] = ckc;
  end

  p_clk_veto_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_lock && !soft_clr) |=> $stable(ckc[CK_OSCD:CK_MSTOP]));
  p_stop_veto_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_lock && !soft_clr) |=> $stable(ckc[CK_STOP]));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sfr_one_wait,
  output logic              wdt_src_ring,
  output logic              wdt_run_in_wait,
  output logic              nmi_pin_en,
  output logic              bclk_keep,
  output logic              main_clk_stop,
  output logic              cpu_clk_sel,
  output logic              stop_mode_req,
  output logic              osc_det_en,
  output logic              swrst_pulse,
  output logic              swrst_seen
);
  logic hit_prot, hit_pm0, hit_pm2, hit_ckc;
  logic pm_en, clk_lock, wdt_lock;
  logic [CK_BITS-1:0] ckc;
  logic [DATA_W-1:0]  prot_rd, pm2_rd, ckc_rd;

  assign hit_prot = bus_addr == ADDR_W'(A_PROT);
  assign hit_pm0  = bus_addr == ADDR_W'(A_PM0);
  assign hit_pm2  = bus_addr == ADDR_W'(A_PM2);
  assign hit_ckc  = bus_addr == ADDR_W'(A_CKC);

  sysctl_prot #(.DATA_W(DATA_W)) u_prot (
    .clk(clk), .rst_n(rst_n),
    .wr_prot(bus_we && hit_prot), .wr_pm0(bus_we && hit_pm0),
    .wdata(bus_wdata), .pm_en(pm_en),
    .swrst_pulse(swrst_pulse), .swrst_seen(swrst_seen)
  );

  sysctl_pmode2 #(.DATA_W(DATA_W)) u_pm2 (
    .clk(clk), .rst_n(rst_n), .soft_clr(swrst_pulse),
    .wr_pm2(bus_we && hit_pm2), .pm_en(pm_en), .wdata(bus_wdata),
    .wait_one(sfr_one_wait), .clk_lock(clk_lock), .wdt_lock(wdt_lock),
    .nmi_en(nmi_pin_en), .rdata(pm2_rd)
  );

  sysctl_clkctl #(.DATA_W(DATA_W)) u_ckc (
    .clk(clk), .rst_n(rst_n), .soft_clr(swrst_pulse),
    .wr_ckc(bus_we && hit_ckc), .wdata(bus_wdata),
    .clk_lock(clk_lock), .wdt_lock(wdt_lock),
    .ckc(ckc), .rdata(ckc_rd)
  );

  assign bclk_keep       = clk_lock;
  assign wdt_src_ring    = wdt_lock;
  assign wdt_run_in_wait = wdt_lock;
  assign main_clk_stop   = ckc[CK_MSTOP];
  assign cpu_clk_sel     = ckc[CK_CSEL];
  assign stop_mode_req   = ckc[CK_STOP];
  assign osc_det_en      = ckc[CK_OSCD];

  always_comb begin
    prot_rd            = '0;
    prot_rd[PROT_PMEN] = pm_en;
  end

  always_comb begin
    if (hit_prot)     bus_rdata = prot_rd;
    else if (hit_pm2) bus_rdata = pm2_rd;
    else if (hit_ckc) bus_rdata = ckc_rd;
    else              bus_rdata = '0;
  end

  p_soft_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_pulse |=> (pm2_rd == '0 && ckc == '0 && swrst_seen));
endmodule

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic sfr_one_wait, wdt_src_ring, wdt_run_in_wait, nmi_pin_en, bclk_keep;
  logic main_clk_stop, cpu_clk_sel, stop_mode_req, osc_det_en;
  logic swrst_pulse, swrst_seen;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata),
    .sfr_one_wait(sfr_one_wait), .wdt_src_ring(wdt_src_ring),
    .wdt_run_in_wait(wdt_run_in_wait), .nmi_pin_en(nmi_pin_en),
    .bclk_keep(bclk_keep), .main_clk_stop(main_clk_stop),
    .cpu_clk_sel(cpu_clk_sel), .stop_mode_req(stop_mode_req),
    .osc_det_en(osc_det_en), .swrst_pulse(swrst_pulse), .swrst_seen(swrst_seen)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0; bus_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [31:0] outs();
    return {21'd0, sfr_one_wait, wdt_src_ring, wdt_run_in_wait, nmi_pin_en, bclk_keep,
            main_clk_stop, cpu_clk_sel, stop_mode_req, osc_det_en, swrst_pulse, swrst_seen};
  endfunction

  function automatic logic [31:0] pm2_outs(input logic [7:0] p);
    return {21'd0, p[0], p[2], p[2], p[4], p[1], 6'd0};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] exp;
    logic [7:0] m;
    hw_reset();

    // R1 reset state
    rd(8'h04, r); chk("R1 pm0", r, 0);
    rd(8'h06, r); chk("R1 ckc", r, 0);
    rd(8'h0A, r); chk("R1 prot", r, 0);
    rd(8'h1E, r); chk("R1 pm2", r, 0);
    chk("R1 outputs", outs(), 0);

    // R3 protect gate closed
    wr(8'h1E, 8'hFF);
    rd(8'h1E, r); chk("R3 pm2 ignored", r, 0);
    chk("R3 outputs", outs(), 0);
    wr(8'h04, 8'h08);
    chk("R3 no pulse", swrst_pulse, 0);
    @(negedge clk); chk("R3 no pulse later", outs(), 0);

    // R2 protect register
    wr(8'h0A, 8'hFF); rd(8'h0A, r); chk("R2 prot set", r, 8'h02);
    wr(8'h0A, 8'hFD); rd(8'h0A, r); chk("R2 prot clear", r, 8'h00);
    wr(8'h1E, 8'h17); rd(8'h1E, r); chk("R3 after clear", r, 0);

    // R11 command needs bit 3
    wr(8'h0A, 8'h02);
    wr(8'h04, 8'hF7);
    chk("R11 no pulse bit3 clear", swrst_pulse, 0);
    rd(8'h04, r); chk("R6 pm0 reads 0", r, 0);

    // R4 R5 R6 R8 R9 R10 sweep of 0x1E
    for (int v = 0; v < 256; v++) begin
      hw_reset();
      wr(8'h0A, 8'h02);
      wr(8'h1E, v[7:0]);
      exp = v[7:0] & 8'h17;
      rd(8'h1E, r); chk("R4/R6 pm2 write", r, exp);
      chk("R4/R8/R9/R10 outputs", outs(), pm2_outs(exp));
      wr(8'h1E, 8'h00);
      exp = v[7:0] & 8'h16;
      rd(8'h1E, r); chk("R5 set-only", r, exp);
      chk("R5 outputs", outs(), pm2_outs(exp));
    end

    // R7 R8 R9 clock-control sweep under lock combinations
    for (int l = 0; l < 4; l++) begin
      hw_reset();
      wr(8'h0A, 8'h02);
      wr(8'h06, 8'hFF);
      rd(8'h06, r); chk("R7 ckc free write", r, 8'h1F);
      wr(8'h1E, l[0] ? 8'h02 : 8'h00);
      wr(8'h1E, l[1] ? 8'h04 : 8'h00);
      m = (l[0] ? 8'h0F : 8'h00) | (l[1] ? 8'h04 : 8'h00);
      exp = 8'h1F;
      for (int v = 0; v < 256; v++) begin
        wr(8'h06, v[7:0]);
        exp = (exp & m) | (v[7:0] & 8'h1F & ~m);
        rd(8'h06, r); chk("R7/R8/R9 ckc veto", r, exp);
        chk("R7 clock outputs", {28'd0, osc_det_en, stop_mode_req, cpu_clk_sel, main_clk_stop},
            {28'd0, exp[3:0]});
        chk("R8 bclk_keep", bclk_keep, l[0]);
        chk("R9 wdt src", {wdt_src_ring, wdt_run_in_wait}, {l[1], l[1]});
      end
    end

    // R11 R12 software reset
    hw_reset();
    wr(8'h0A, 8'h02);
    wr(8'h06, 8'h1F);
    wr(8'h1E, 8'h17);
    wr(8'h04, 8'h08);
    chk("R11 pulse high", swrst_pulse, 1);
    chk("R12 seen not yet", swrst_seen, 0);
    @(negedge clk);
    chk("R11 pulse one cycle", swrst_pulse, 0);
    chk("R12 seen", swrst_seen, 1);
    rd(8'h0A, r); chk("R12 prot cleared", r, 0);
    rd(8'h1E, r); chk("R12 pm2 cleared", r, 0);
    rd(8'h06, r); chk("R12 ckc cleared", r, 0);
    chk("R12 outputs", outs(), 1);
    repeat (3) @(negedge clk);
    chk("R12 seen sticky", outs(), 1);
    wr(8'h0A, 8'h02);
    wr(8'h1E, 8'h01);
    rd(8'h1E, r); chk("R12 usable after", r, 8'h01);
    chk("R12 seen still", swrst_seen, 1);
    hw_reset();
    chk("R1 hw reset clears seen", outs(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule